// File: doc/BRIEF.md
# Command stream packet decoder

The decoder walks a ring of 32-bit command words in memory. It keeps its own read position and compares it with a write position that a host publishes. Each header word is classified in one of four ways. A packet header carries a method burst. A header with a zero count is a no-op. A flow-control header redirects the read position: a jump, a call with a single-level return, or a return. Any other header is malformed. Every data word of a burst leaves the block as one (method address, data) pair on a register-write port that can be held off by backpressure.

When the read position reaches the host's write position, the decoder waits. This applies between packets and also partway through a burst. It continues as soon as the host moves its pointer. A jump whose target is the jump's own position is treated as the producer's idle loop and raises a spin flag. Call-stack misuse and malformed headers stop the decoder with a sticky error code until reset. The read position is published back to the host at three points: once a burst has fully drained, when a no-op is consumed, and on every taken redirect.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After reset the published pointer is 0, no memory request or register write is pending, the error code is 0 and the spin flag is low.
- R2: For a method header, the burst length is taken from bits 28:18 (11 bits). The first method address is the header ANDed with 0xFFFC. Bit 30 set selects fixed-address mode. A method header has none of bits 31, 29, 17, 16, 1 or 0 set.
- R3: In incrementing mode each successive data word is written to the previous method address plus 4. In fixed-address mode every data word of the burst goes to the same address.
- R4: A method header with a count of 0 is a no-op. It produces no register write, and the published pointer becomes the header position plus 4.
- R5: The host write position is compared with its two low bits cleared. While the read position equals it, no memory request is made and ring_empty is high, both between packets and inside a burst. Decoding resumes when the host pointer advances.
- R6: The published pointer is left unchanged while a burst is draining. Once the last data word has been accepted, it becomes header position + 4*(count+1).
- R7: Two jump forms exist. In the first, bits 31:29 = 001 and bits 1:0 = 00, with the target equal to the header ANDed with 0x1FFFFFFC. In the second, bits 1:0 = 01, with the target equal to the header with bits 1:0 cleared. A taken jump loads the read position with the target and publishes it.
- R8: A jump whose target equals its own header position sets idle_spin. The next header that is not such a self-jump clears it.
- R9: A call (bits 1:0 = 10) saves its position + 4 and continues at the header with bits 1:0 cleared. A return (the exact word 0x00020000) continues at the saved position and empties the return slot.
- R10: A call while a return position is already held sets error code 2 and halts.
- R11: A return while no return position is held sets error code 3 and halts.
- R12: A header with non-method bits set that matches none of the jump, call or return forms sets error code 1 and halts. While halted, no memory request and no register write is made.
- R13: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| put_ptr | input | AW | Host write position (byte address) |
| get_ptr | output | AW | Published read position |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read response strobe, one per accepted request |
| mem_rsp_data | input | 32 | Read response word |
| wr_valid | output | 1 | Register write available |
| wr_ready | input | 1 | Downstream accepts the write |
| wr_addr | output | 16 | Method register byte address |
| wr_data | output | 32 | Method data word |
| ring_empty | output | 1 | Read position has caught up with the host pointer |
| idle_spin | output | 1 | Producer is looping on a self-jump |
| err_code | output | 2 | 0 none, 1 malformed, 2 nested call, 3 unmatched return |

## Verification
A header reaches the decoder one cycle after its fetch is accepted, and any redirect or no-op is visible on get_ptr on the following edge. A data word appears on wr_valid two cycles after its fetch is accepted, and the published pointer moves one cycle after the last write handshake. Because backpressure and fetch latency stretch these delays by an amount that depends on the stimulus, the bench never samples at a fixed offset. It logs every write handshake at the clock edge, lets each program run for a bounded settling window, and then compares the log, get_ptr and the status outputs at a falling edge against values computed from the program it wrote.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int WORD_W  = 32;
  localparam int CNT_W   = 11;
  localparam int MADDR_W = 16;

  typedef enum logic [2:0] {
    K_METHOD,
    K_NOP,
    K_JUMP,
    K_CALL,
    K_RET,
    K_BAD
  } hdr_kind_e;

  typedef enum logic [1:0] {
    ERR_NONE        = 2'd0,
    ERR_MALFORMED   = 2'd1,
    ERR_NESTED_CALL = 2'd2,
    ERR_ORPHAN_RET  = 2'd3
  } err_e;

  typedef struct packed {
    hdr_kind_e          kind;
    logic [CNT_W-1:0]   count;
    logic [MADDR_W-1:0] maddr;
    logic               fixed;
    logic [WORD_W-1:0]  target;
  } hdr_info_t;

  // burst length field
  function automatic logic [CNT_W-1:0] hdr_count(input logic [WORD_W-1:0] h);
    return h[28:18];
  endfunction

  // first method register address, word aligned
  function automatic logic [MADDR_W-1:0] hdr_maddr(input logic [WORD_W-1:0] h);
    return h[MADDR_W-1:0] & 16'hFFFC;
  endfunction

  function automatic logic hdr_fixed(input logic [WORD_W-1:0] h);
    return h[30];
  endfunction

  function automatic logic hdr_nonmethod(input logic [WORD_W-1:0] h);
    return h[31] | h[29] | h[17] | h[16] | h[1] | h[0];
  endfunction

  function automatic logic hdr_jump_a(input logic [WORD_W-1:0] h);
    return (h[31:29] == 3'b001) && (h[1:0] == 2'b00);
  endfunction

  function automatic logic hdr_jump_b(input logic [WORD_W-1:0] h);
    return h[1:0] == 2'b01;
  endfunction

  function automatic logic hdr_call(input logic [WORD_W-1:0] h);
    return h[1:0] == 2'b10;
  endfunction

  function automatic logic hdr_ret(input logic [WORD_W-1:0] h);
    return h == 32'h0002_0000;
  endfunction

  function automatic logic [WORD_W-1:0] jump_a_target(input logic [WORD_W-1:0] h);
    return h & 32'h1FFF_FFFC;
  endfunction

  function automatic logic [WORD_W-1:0] flow_target(input logic [WORD_W-1:0] h);
    return h & 32'hFFFF_FFFC;
  endfunction

  // address of the next data word in a burst
  function automatic logic [MADDR_W-1:0] next_maddr(input logic [MADDR_W-1:0] a,
                                                    input logic fixed);
    return fixed ? a : a + MADDR_W'(4);
  endfunction

endpackage

// File: rtl/cmdq_hdr_decode.sv
module cmdq_hdr_decode
  import cmdq_pkg::*;
(
  input  logic [WORD_W-1:0] hdr,
  output hdr_info_t         info
);

  always_comb begin
    info.count  = hdr_count(hdr);
    info.maddr  = hdr_maddr(hdr);
    info.fixed  = hdr_fixed(hdr);
    info.target = flow_target(hdr);
    if (!hdr_nonmethod(hdr)) begin
      info.kind = (hdr_count(hdr) == '0) ? K_NOP : K_METHOD;
    end else if (hdr_jump_a(hdr)) begin
      info.kind   = K_JUMP;
      info.target = jump_a_target(hdr);
    end else if (hdr_jump_b(hdr)) begin
      info.kind = K_JUMP;
    end else if (hdr_call(hdr)) begin
      info.kind = K_CALL;
    end else if (hdr_ret(hdr)) begin
      info.kind = K_RET;
    end else begin
      info.kind = K_BAD;
    end
  end

endmodule

// File: rtl/cmdq_ret_slot.sv
module cmdq_ret_slot #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic          held,
  output logic [AW-1:0] ret_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      ret_addr <= '0;
    end else if (push) begin
      held     <= 1'b1;
      ret_addr <= push_addr;
    end else if (pop) begin
      held <= 1'b0;
    end
  end

endmodule

// File: rtl/cmdq_burst_ctr.sv
module cmdq_burst_ctr
  import cmdq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CNT_W-1:0]   ld_count,
  input  logic [MADDR_W-1:0] ld_addr,
  input  logic               ld_fixed,
  input  logic               step,
  output logic [MADDR_W-1:0] cur_addr,
  output logic               last
);

  logic [CNT_W-1:0] remain_q;
  logic             fixed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      cur_addr <= '0;
      fixed_q  <= 1'b0;
    end else if (load) begin
      remain_q <= ld_count;
      cur_addr <= ld_addr;
      fixed_q  <= ld_fixed;
    end else if (step) begin
      remain_q <= remain_q - CNT_W'(1);
      cur_addr <= next_maddr(cur_addr, fixed_q);
    end
  end

  assign last = (remain_q == CNT_W'(1));

endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cmdq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      put_ptr,
  output logic [AW-1:0]      get_ptr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [AW-1:0]      mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [WORD_W-1:0]  mem_rsp_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [MADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0]  wr_data,
  output logic               ring_empty,
  output logic               idle_spin,
  output logic [1:0]         err_code
);

  localparam logic [AW-1:0] STEP  = AW'(4);
  localparam logic [AW-1:0] ALIGN = ~AW'(3);

  typedef enum logic [2:0] {
    ST_HREQ, ST_HWAIT, ST_DREQ, ST_DWAIT, ST_EMIT, ST_HALT
  } st_e;

  st_e                state;
  logic [AW-1:0]      rd_ptr;
  logic [WORD_W-1:0]  data_q;
  err_e               err_q;
  logic               spin_q;

  // named internal events
  logic          put_al_eq;
  logic          fetch_phase;
  logic          hdr_take;
  logic          dat_take;
  logic          wr_fire;
  logic          self_jump;
  logic [AW-1:0] tgt;
  logic [AW-1:0] rd_next;
  hdr_info_t     info;
  logic          ret_held;
  logic [AW-1:0] ret_addr;
  logic          burst_last;
  logic          ret_push;
  logic          ret_pop;
  logic          burst_load;

  assign put_al_eq   = (rd_ptr == (put_ptr & ALIGN));
  assign fetch_phase = (state == ST_HREQ) || (state == ST_DREQ);
  assign hdr_take    = (state == ST_HWAIT) && mem_rsp_valid;
  assign dat_take    = (state == ST_DWAIT) && mem_rsp_valid;
  assign wr_fire     = wr_valid && wr_ready;
  assign tgt         = info.target[AW-1:0];
  assign self_jump   = (tgt == rd_ptr);
  assign rd_next     = rd_ptr + STEP;
  assign ret_push    = hdr_take && (info.kind == K_CALL) && !ret_held;
  assign ret_pop     = hdr_take && (info.kind == K_RET) && ret_held;
  assign burst_load  = hdr_take && (info.kind == K_METHOD);

  cmdq_hdr_decode u_dec (
    .hdr  (mem_rsp_data),
    .info (info)
  );

  cmdq_ret_slot #(.AW(AW)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ret_push),
    .pop       (ret_pop),
    .push_addr (rd_next),
    .held      (ret_held),
    .ret_addr  (ret_addr)
  );

  cmdq_burst_ctr u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (burst_load),
    .ld_count (info.count),
    .ld_addr  (info.maddr),
    .ld_fixed (info.fixed),
    .step     (wr_fire),
    .cur_addr (wr_addr),
    .last     (burst_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_HREQ;
      rd_ptr  <= '0;
      get_ptr <= '0;
      data_q  <= '0;
      err_q   <= ERR_NONE;
      spin_q  <= 1'b0;
    end else begin
      case (state)
        ST_HREQ: begin
          if (mem_req_valid && mem_req_ready) state <= ST_HWAIT;
        end
        ST_HWAIT: begin
          if (hdr_take) begin
            case (info.kind)
              K_NOP: begin
                rd_ptr  <= rd_next;
                get_ptr <= rd_next;
                spin_q  <= 1'b0;
                state   <= ST_HREQ;
              end
              K_METHOD: begin
                rd_ptr <= rd_next;
                spin_q <= 1'b0;
                state  <= ST_DREQ;
              end
              K_JUMP: begin
                rd_ptr  <= tgt;
                get_ptr <= tgt;
                spin_q  <= self_jump;
                state   <= ST_HREQ;
              end
              K_CALL: begin
                spin_q <= 1'b0;
                if (ret_held) begin
                  err_q <= ERR_NESTED_CALL;
                  state <= ST_HALT;
                end else begin
                  rd_ptr  <= tgt;
                  get_ptr <= tgt;
                  state   <= ST_HREQ;
                end
              end
              K_RET: begin
                spin_q <= 1'b0;
                if (!ret_held) begin
                  err_q <= ERR_ORPHAN_RET;
                  state <= ST_HALT;
                end else begin
                  rd_ptr  <= ret_addr;
                  get_ptr <= ret_addr;
                  state   <= ST_HREQ;
                end
              end
              default: begin
                spin_q <= 1'b0;
                err_q  <= ERR_MALFORMED;
                state  <= ST_HALT;
              end
            endcase
          end
        end
        ST_DREQ: begin
          if (mem_req_valid && mem_req_ready) state <= ST_DWAIT;
        end
        ST_DWAIT: begin
          if (dat_take) begin
            data_q <= mem_rsp_data;
            state  <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (wr_fire) begin
            rd_ptr <= rd_next;
            if (burst_last) begin
              get_ptr <= rd_next;
              state   <= ST_HREQ;
            end else begin
              state <= ST_DREQ;
            end
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign mem_req_valid = fetch_phase && !put_al_eq;
  assign mem_req_addr  = rd_ptr;
  assign ring_empty    = fetch_phase && put_al_eq;
  assign wr_valid      = (state == ST_EMIT);
  assign wr_data       = data_q;
  assign idle_spin     = spin_q;
  assign err_code      = err_q;

endmodule

// File: rtl/cmdq_chk.sv
module cmdq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] get_ptr,
  input logic          mem_req_valid,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [15:0]   wr_addr,
  input logic [31:0]   wr_data,
  input logic          ring_empty,
  input logic          idle_spin,
  input logic [1:0]    err_code
);

  // R13
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R5
  empty_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_empty |-> !mem_req_valid);

  // R12
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_code != 2'd0 |=> $stable(err_code) && !mem_req_valid && !wr_valid);

  // R8
  spin_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_spin |-> !wr_valid);

  // R6
  get_mid_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> $stable(get_ptr) || !wr_valid || $past(wr_ready));

endmodule

bind cmd_stream_decoder cmdq_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .get_ptr       (get_ptr),
  .mem_req_valid (mem_req_valid),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .ring_empty    (ring_empty),
  .idle_spin     (idle_spin),
  .err_code      (err_code)
);

// File: tb/sim_cmd_stream_decoder.sv
module sim_cmd_stream_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_LEN    = 160;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] put_ptr = '0;
  logic [31:0] get_ptr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        wr_valid;
  logic        wr_ready;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        ring_empty;
  logic        idle_spin;
  logic [1:0]  err_code;

  int checks = 0;
  int fails  = 0;
  bit bp_on  = 1'b0;
  bit done   = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] mem [0:63];
  logic [15:0] log_addr [0:255];
  logic [31:0] log_data [0:255];
  int          log_n = 0;
  logic [15:0] exp_addr [0:255];
  logic [31:0] exp_data [0:255];
  int          exp_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_stream_decoder u0 (
    .clk (clk), .rst_n (rst_n), .put_ptr (put_ptr), .get_ptr (get_ptr),
    .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
    .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data), .wr_valid (wr_valid), .wr_ready (wr_ready),
    .wr_addr (wr_addr), .wr_data (wr_data), .ring_empty (ring_empty),
    .idle_spin (idle_spin), .err_code (err_code)
  );

  // memory model: one response word the cycle after acceptance
  always @(posedge clk) begin
    mem_rsp_valid <= rst_n && mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem[mem_req_addr[7:2]];
    if (rst_n && wr_valid && wr_ready && log_n < 256) begin
      log_addr[log_n] = wr_addr;
      log_data[log_n] = wr_data;
      log_n = log_n + 1;
    end
  end

  // ready pattern
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready      = bp_on ? lfsr[0] : 1'b1;
    mem_req_ready = bp_on ? lfsr[3] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    exp_n = 0;
  endtask

  task automatic emit_burst(input int at, input int cnt, input int ma, input bit fixed,
                            input int tag);
    mem[at/4] = (32'(fixed) << 30) | (32'(cnt) << 18) | 32'(ma);
    for (int i = 0; i < cnt; i++) begin
      mem[at/4 + 1 + i] = 32'hA500_0000 + 32'(tag << 8) + 32'(i);
      exp_addr[exp_n] = 16'(ma + (fixed ? 0 : 4*i));
      exp_data[exp_n] = 32'hA500_0000 + 32'(tag << 8) + 32'(i);
      exp_n++;
    end
  endtask

  task automatic start(input logic [31:0] put);
    @(negedge clk);
    rst_n = 1'b0;
    put_ptr = put;
    repeat (3) @(negedge clk);
    log_n = 0;
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp_log(input string req);
    chk(log_n == exp_n, {req, " write count"}, 32'(log_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_addr[i] == exp_addr[i], {req, " write addr"}, 32'(log_addr[i]), 32'(exp_addr[i]));
      chk(log_data[i] == exp_data[i], {req, " write data"}, log_data[i], exp_data[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    clear_prog();
    start(32'h0);
    run(2);
    chk(get_ptr == 0, "R1 get", get_ptr, 0);
    chk(!mem_req_valid, "R1 req", 32'(mem_req_valid), 0);
    chk(!wr_valid, "R1 wr", 32'(wr_valid), 0);
    chk(err_code == 0, "R1 err", 32'(err_code), 0);
    chk(!idle_spin, "R1 spin", 32'(idle_spin), 0);

    // R2 R3 R6 R13 sweep: length, mode, backpressure
    for (int bp = 0; bp < 2; bp++)
      for (int fx = 0; fx < 2; fx++)
        for (int c = 1; c <= 6; c++) begin
          clear_prog();
          bp_on = bp[0];
          emit_burst(0, c, 16'h1234 + 16'(c*16), fx[0], c + 8*fx);
          start(32'(4*(c+1)));
          run(RUN_LEN);
          cmp_log(fx ? "R3 fixed" : (bp ? "R13 bp" : "R2 incr"));
          chk(get_ptr == 32'(4*(c+1)), "R6 get after burst", get_ptr, 32'(4*(c+1)));
          chk(ring_empty, "R5 empty at end", 32'(ring_empty), 1);
        end
    bp_on = 1'b0;

    // R4 no-op alone, then no-op followed by burst
    clear_prog();
    mem[0] = 32'h0000_0000;
    start(32'h4);
    run(40);
    chk(log_n == 0, "R4 nop writes", 32'(log_n), 0);
    chk(get_ptr == 32'h4, "R4 nop get", get_ptr, 32'h4);
    clear_prog();
    mem[0] = 32'h4000_0000;
    emit_burst(4, 2, 16'h0040, 1'b0, 30);
    start(32'd16);
    run(60);
    cmp_log("R4 nop then burst");
    chk(get_ptr == 32'd16, "R4 get", get_ptr, 32'd16);

    // R5 R6 stall inside a burst, PUT low bits ignored
    clear_prog();
    emit_burst(0, 4, 16'h0200, 1'b0, 31);
    start(32'd8);
    run(40);
    chk(log_n == 1, "R5 stalled writes", 32'(log_n), 1);
    chk(ring_empty, "R5 empty mid burst", 32'(ring_empty), 1);
    chk(!mem_req_valid, "R5 no request", 32'(mem_req_valid), 0);
    chk(get_ptr == 0, "R6 get mid burst", get_ptr, 0);
    put_ptr = 32'd20 | 32'd3;
    run(60);
    cmp_log("R5 resume");
    chk(get_ptr == 32'd20, "R5 get low bits", get_ptr, 32'd20);

    // R7 both jump forms
    for (int form = 0; form < 2; form++) begin
      clear_prog();
      mem[0] = form ? 32'h0000_0041 : 32'h2000_0040;
      emit_burst(32'h40, 1, 16'h0300, 1'b0, 32 + form);
      start(32'h48);
      run(60);
      cmp_log("R7 jump");
      chk(get_ptr == 32'h48, "R7 get", get_ptr, 32'h48);
      chk(!idle_spin, "R7 spin", 32'(idle_spin), 0);
    end

    // R8 self jump spin, released by rewriting to no-ops
    clear_prog();
    mem[0] = 32'h0000_0001;
    start(32'h10);
    run(40);
    chk(idle_spin, "R8 spin set", 32'(idle_spin), 1);
    chk(get_ptr == 0, "R8 get", get_ptr, 0);
    chk(log_n == 0, "R8 writes", 32'(log_n), 0);
    for (int i = 0; i < 4; i++) mem[i] = 32'h0;
    run(40);
    chk(!idle_spin, "R8 spin cleared", 32'(idle_spin), 0);
    chk(get_ptr == 32'h10, "R8 get after", get_ptr, 32'h10);

    // R9 call and return
    clear_prog();
    mem[0] = 32'h0000_0082;
    emit_burst(32'h80, 1, 16'h0300, 1'b0, 40);
    mem[32'h88/4] = 32'h0002_0000;
    emit_burst(4, 2, 16'h0310, 1'b0, 41);
    start(32'd16);
    run(80);
    cmp_log("R9 call return");
    chk(get_ptr == 32'd16, "R9 get", get_ptr, 32'd16);
    chk(err_code == 0, "R9 err", 32'(err_code), 0);

    // R10 nested call
    clear_prog();
    mem[0] = 32'h0000_0042;
    mem[32'h40/4] = 32'h0000_0082;
    emit_burst(32'h80, 1, 16'h0300, 1'b0, 42);
    start(32'h90);
    run(60);
    chk(err_code == 2, "R10 err", 32'(err_code), 2);
    chk(log_n == 0, "R10 writes", 32'(log_n), 0);
    chk(!mem_req_valid, "R10 halted", 32'(mem_req_valid), 0);

    // R11 return without call
    clear_prog();
    mem[0] = 32'h0002_0000;
    start(32'h10);
    run(40);
    chk(err_code == 3, "R11 err", 32'(err_code), 3);
    chk(get_ptr == 0, "R11 get", get_ptr, 0);

    // R12 malformed headers
    for (int k = 0; k < 5; k++) begin
      logic [31:0] bad;
      case (k)
        0: bad = 32'h0001_0000;
        1: bad = 32'h8000_0000;
        2: bad = 32'h0000_0003;
        3: bad = 32'hE000_0000;
        default: bad = 32'h0002_0004;
      endcase
      clear_prog();
      mem[0] = bad;
      emit_burst(4, 1, 16'h0100, 1'b0, 50);
      start(32'h10);
      run(40);
      chk(err_code == 1, "R12 err", 32'(err_code), 1);
      chk(log_n == 0, "R12 writes", 32'(log_n), 0);
      chk(!mem_req_valid && !wr_valid, "R12 halted", 32'(mem_req_valid | wr_valid), 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule